// File: doc/BRIEF.md
# SPI Receive Capture with Echoed-Clock Option

This block is the receive half of an SPI master. After a start strobe it drives a serial clock for a programmed number of bits. It shifts in one word from each of several SDI lines in parallel, most significant bit first. It then presents the words as parallel data with a one-cycle valid strobe. Everything it drives runs in the system (SPI) clock domain.

A build-time parameter selects where the SDI lines are sampled.

- With the option off, each line is sampled by the system clock on the edge at which the generated SCLK rises.
- With it on, each line is sampled on rising edges of a copy of SCLK that the target board returns. That copy has passed through the same slow level shifter or isolator as the data, so the round-trip delay drops out of the timing budget.

In echo mode, a bit counter in the returned-clock domain flips a completion flag after the last bit. The flag is brought into the system clock domain through a two-flop synchronizer. Its edge copies the shifted words into a holding register and raises the valid strobe.

The controller is a four-state machine:

| State | Meaning | Transitions |
|---|---|---|
| IDLE | SCLK held low | Goes to LOW on an accepted start |
| LOW | SCLK low phase | Goes to HIGH after `HALF_DIV` cycles |
| HIGH | SCLK high phase | After `HALF_DIV` cycles, goes back to LOW, or to WAIT once the programmed bit count is reached |
| WAIT | SCLK stopped | Goes to IDLE once the capture path reports completion |

Top module: `spi_echo_rx`

## Requirements
- R1: While `rst` is high and right after it falls, `sclk_o` and `rx_valid_o` are 0 and `rx_data_o` is all zeros.
- R2: A `start_i` pulse in IDLE with `len_i` in 1..`MAX_BITS` produces exactly `len_i` SCLK pulses. Each pulse is `HALF_DIV` clock cycles low followed by `HALF_DIV` clock cycles high, and `sclk_o` is low whenever the controller is idle.
- R3: A `start_i` pulse while a transfer is in progress is ignored: the running transfer keeps its pulse count and its captured data.
- R4: A `start_i` pulse with `len_i` equal to 0 or above `MAX_BITS` is ignored: no SCLK pulse and no valid strobe follow.
- R5: With `ECHO_MODE`=0, each SDI line is sampled at the `clk` edge where `sclk_o` rises. The first bit sampled becomes bit `len-1` and the last bit becomes bit 0.
- R6: With `ECHO_MODE`=1, each SDI line is sampled on rising edges of `echo_sclk_i`, with the same MSB-first bit placement as R5.
- R7: `rx_valid_o` is a one-cycle pulse in the `clk` domain, given exactly once per accepted transfer and only after the last SDI bit has been latched. With `ECHO_MODE`=0 it is high in the cycle after the `clk` edge that latched the last bit.
- R8: `rx_data_o` changes only in cycles where `rx_valid_o` is high, so it is stable from one strobe to the next.
- R9: Line k occupies bits `[k*MAX_BITS +: MAX_BITS]` of `rx_data_o`. The word is right-justified, with bits at and above `len` set to zero, and the lines are captured independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System / SPI clock |
| rst | input | 1 | Active-high reset, synchronous to `clk` |
| start_i | input | 1 | One-cycle strobe that begins a transfer |
| len_i | input | $clog2(MAX_BITS+1) | Number of bits to transfer |
| echo_sclk_i | input | 1 | SCLK as returned by the target board |
| sdi_i | input | NUM_SDI | Serial data lines from the target |
| sclk_o | output | 1 | Generated serial clock, idles low |
| rx_data_o | output | NUM_SDI*MAX_BITS | Received words, one field per line |
| rx_valid_o | output | 1 | One-cycle strobe marking new `rx_data_o` |

## Verification
The bench runs one instance in echo mode and one in direct mode side by side.

In echo mode, the returned clock lags the generated clock by more than a full system cycle. A design that sampled on its own SCLK there would capture shifted or stale bits.

Transfers of length 1 and 32 probe the ends of the counter and the mask:
- An off-by-one in the bit count shows up as a wrong number of SCLK pulses or a missing valid strobe.
- A wrong mask leaves stale bits above the word.

A start pulse in the middle of a transfer, and starts with lengths 0 and 40, catch a controller that restarts or runs on bad input. The bench compares valid and data on every cycle, so an extra or doubled strobe, or data that moves between strobes, is also reported.

// File: rtl/spi_echo_rx_pkg.sv
package spi_echo_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_WAIT = 2'd3
    } rx_state_e;

endpackage

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
    import spi_echo_rx_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int HALF_DIV = 2,
    parameter int LW       = $clog2(MAX_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [LW-1:0] len_i,
    input  logic          done_i,
    output logic          sclk_o,
    output logic          sample_o,
    output logic          last_o,
    output logic [LW-1:0] len_o,
    output logic [LW-1:0] bit_cnt_o,
    output rx_state_e     state_o
);

    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    rx_state_e     state, state_nx;
    logic [DW-1:0] div_cnt;
    logic [LW-1:0] bit_cnt;
    logic [LW-1:0] len_q;
    logic          done_seen;
    logic          sclk_q;
    logic          len_ok;
    logic          div_end;
    logic          accept;

    assign len_ok  = (len_i != '0) && (len_i <= LW'(MAX_BITS));
    assign div_end = (div_cnt == DW'(HALF_DIV - 1));
    assign accept  = (state == ST_IDLE) && start_i && len_ok;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)  state_nx = ST_LOW;
            ST_LOW:  if (div_end) state_nx = ST_HIGH;
            ST_HIGH: if (div_end) state_nx = (bit_cnt == len_q) ? ST_WAIT : ST_LOW;
            ST_WAIT: if (done_i || done_seen) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // datapath and registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt   <= '0;
            bit_cnt   <= '0;
            len_q     <= '0;
            done_seen <= 1'b0;
            sclk_q    <= 1'b0;
        end else begin
            sclk_q <= (state_nx == ST_HIGH);
            if (state != state_nx || state == ST_IDLE || state == ST_WAIT)
                div_cnt <= '0;
            else
                div_cnt <= div_cnt + 1'b1;
            if (accept) begin
                len_q     <= len_i;
                bit_cnt   <= '0;
                done_seen <= 1'b0;
            end else begin
                if (sample_o) bit_cnt <= bit_cnt + 1'b1;
                if (done_i && state != ST_IDLE) done_seen <= 1'b1;
            end
        end
    end

    assign sample_o  = (state == ST_LOW) && div_end;
    assign last_o    = sample_o && (LW'(bit_cnt + 1'b1) == len_q);
    assign sclk_o    = sclk_q;
    assign len_o     = len_q;
    assign bit_cnt_o = bit_cnt;
    assign state_o   = state;

endmodule

// File: rtl/spi_rx_lane.sv
module spi_rx_lane #(
    parameter int W = 32
) (
    input  logic         cap_clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sdi,
    output logic [W-1:0] word_o
);

    logic [W-1:0] shreg;

    always_ff @(posedge cap_clk or posedge rst) begin
        if (rst)     shreg <= '0;
        else if (en) shreg <= {shreg[W-2:0], sdi};
    end

    assign word_o = shreg;

endmodule

// File: rtl/spi_rx_capture.sv
module spi_rx_capture #(
    parameter int NUM_SDI   = 2,
    parameter int MAX_BITS  = 32,
    parameter int LW        = $clog2(MAX_BITS + 1),
    parameter bit ECHO_MODE = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        echo_sclk_i,
    input  logic [NUM_SDI-1:0]          sdi_i,
    input  logic                        sample_i,
    input  logic                        last_i,
    input  logic [LW-1:0]               len_i,
    output logic [NUM_SDI*MAX_BITS-1:0] shreg_o,
    output logic                        done_o
);

    logic cap_clk;
    logic cap_en;

    generate
        if (ECHO_MODE) begin : g_echo
            logic [LW-1:0] ecnt;
            logic          tgl;
            logic [2:0]    sync;
            logic          unused_direct;

            assign cap_clk       = echo_sclk_i;
            assign cap_en        = 1'b1;
            assign unused_direct = sample_i ^ last_i;

            // returned-clock bit counter, flips the flag on the final bit
            always_ff @(posedge echo_sclk_i or posedge rst) begin
                if (rst) begin
                    ecnt <= '0;
                    tgl  <= 1'b0;
                end else if (LW'(ecnt + 1'b1) == len_i) begin
                    ecnt <= '0;
                    tgl  <= ~tgl;
                end else begin
                    ecnt <= ecnt + 1'b1;
                end
            end

            // two-flop synchronizer plus edge-detect stage
            always_ff @(posedge clk) begin
                if (rst) sync <= '0;
                else     sync <= {sync[1:0], tgl};
            end

            assign done_o = sync[2] ^ sync[1];
        end else begin : g_direct
            logic          done_r;
            logic          unused_echo;
            logic [LW-1:0] unused_len;

            assign cap_clk     = clk;
            assign cap_en      = sample_i;
            assign unused_echo = echo_sclk_i;
            assign unused_len  = len_i;

            always_ff @(posedge clk) begin
                if (rst) done_r <= 1'b0;
                else     done_r <= last_i;
            end

            assign done_o = done_r;
        end
    endgenerate

    generate
        for (genvar g = 0; g < NUM_SDI; g++) begin : g_lane
            spi_rx_lane #(.W(MAX_BITS)) u_lane (
                .cap_clk (cap_clk),
                .rst     (rst),
                .en      (cap_en),
                .sdi     (sdi_i[g]),
                .word_o  (shreg_o[g*MAX_BITS +: MAX_BITS])
            );
        end
    endgenerate

endmodule

// File: rtl/spi_echo_rx.sv
module spi_echo_rx
    import spi_echo_rx_pkg::*;
#(
    parameter int NUM_SDI   = 2,
    parameter int MAX_BITS  = 32,
    parameter int HALF_DIV  = 2,
    parameter bit ECHO_MODE = 1'b1,
    parameter int LW        = $clog2(MAX_BITS + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic [LW-1:0]               len_i,
    input  logic                        echo_sclk_i,
    input  logic [NUM_SDI-1:0]          sdi_i,
    output logic                        sclk_o,
    output logic [NUM_SDI*MAX_BITS-1:0] rx_data_o,
    output logic                        rx_valid_o
);

    localparam int DATA_W = NUM_SDI * MAX_BITS;

    logic                sample;
    logic                last;
    logic                done;
    logic [LW-1:0]       len_q;
    logic [LW-1:0]       bit_cnt;
    rx_state_e           state;
    logic [DATA_W-1:0]   shreg;
    logic [DATA_W-1:0]   hold;
    logic [MAX_BITS-1:0] mask;
    logic                valid_q;

    spi_rx_ctrl #(
        .MAX_BITS (MAX_BITS),
        .HALF_DIV (HALF_DIV),
        .LW       (LW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .len_i     (len_i),
        .done_i    (done),
        .sclk_o    (sclk_o),
        .sample_o  (sample),
        .last_o    (last),
        .len_o     (len_q),
        .bit_cnt_o (bit_cnt),
        .state_o   (state)
    );

    spi_rx_capture #(
        .NUM_SDI   (NUM_SDI),
        .MAX_BITS  (MAX_BITS),
        .LW        (LW),
        .ECHO_MODE (ECHO_MODE)
    ) u_cap (
        .clk         (clk),
        .rst         (rst),
        .echo_sclk_i (echo_sclk_i),
        .sdi_i       (sdi_i),
        .sample_i    (sample),
        .last_i      (last),
        .len_i       (len_q),
        .shreg_o     (shreg),
        .done_o      (done)
    );

    // keep only the bits below the programmed length (R9)
    always_comb begin
        for (int i = 0; i < MAX_BITS; i++)
            mask[i] = (i < int'(len_q));
    end

    generate
        for (genvar g = 0; g < NUM_SDI; g++) begin : g_hold
            always_ff @(posedge clk) begin
                if (rst)       hold[g*MAX_BITS +: MAX_BITS] <= '0;
                else if (done) hold[g*MAX_BITS +: MAX_BITS] <= shreg[g*MAX_BITS +: MAX_BITS] & mask;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= done;
    end

    assign rx_data_o  = hold;
    assign rx_valid_o = valid_q;

endmodule

// File: rtl/spi_echo_rx_chk.sv
module spi_echo_rx_chk
    import spi_echo_rx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LW     = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [LW-1:0]     len_i,
    input logic              sclk_o,
    input logic              rx_valid_o,
    input logic [DATA_W-1:0] rx_data_o,
    input rx_state_e         state,
    input logic [LW-1:0]     len_q,
    input logic [LW-1:0]     bit_cnt
);

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    assert_idle_sclk_low_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sclk_o);

    assert_bits_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> (bit_cnt <= len_q));

    assert_busy_start_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start_i) |=> $stable(len_q));

    assert_bad_len_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start_i && len_i == '0) |=> (state == ST_IDLE));

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rx_valid_o |-> $stable(rx_data_o));

endmodule

bind spi_echo_rx spi_echo_rx_chk #(
    .DATA_W (NUM_SDI * MAX_BITS),
    .LW     (LW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .len_i      (len_i),
    .sclk_o     (sclk_o),
    .rx_valid_o (rx_valid_o),
    .rx_data_o  (rx_data_o),
    .state      (state),
    .len_q      (len_q),
    .bit_cnt    (bit_cnt)
);

// File: tb/sim_spi_echo_rx.sv
`timescale 1ns/1ps
module sim_spi_echo_rx;

    localparam int CLK_PERIOD = 10;
    localparam int NS  = 2;
    localparam int MB  = 32;
    localparam int LW  = 6;
    localparam int DW  = NS * MB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [LW-1:0] len_in = '0;
    logic tgt_load = 1'b0;

    logic sclk0, sclk1, valid0, valid1;
    logic [DW-1:0] data0, data1;
    logic tclk0 = 1'b0, tclk1 = 1'b0;
    logic [NS-1:0] sdi0, sdi1;
    int pos0 = 0, pos1 = 0;
    int cur_len = 0;
    logic [MB-1:0] pat [NS];

    int compared = 0, mismatched = 0;
    int cyc = 0;
    bit finished = 1'b0;
    bit running = 1'b0;

    logic [DW-1:0] exp_word [64];
    int exp_len [64];
    int tail = 0;
    int head [2] = '{0, 0};
    int rises [2] = '{0, 0};
    logic prev_s [2] = '{1'b0, 1'b0};
    logic [DW-1:0] last_d [2];
    int rise_cyc1 = 0;
    realtime t_echo = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // u0: returned clock lags well over one system cycle (R6)
    spi_echo_rx #(.NUM_SDI(NS), .MAX_BITS(MB), .HALF_DIV(2), .ECHO_MODE(1'b1)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .len_i(len_in),
        .echo_sclk_i(tclk0), .sdi_i(sdi0),
        .sclk_o(sclk0), .rx_data_o(data0), .rx_valid_o(valid0));

    // u1: direct sampling on the generated clock (R5)
    spi_echo_rx #(.NUM_SDI(NS), .MAX_BITS(MB), .HALF_DIV(2), .ECHO_MODE(1'b0)) u1 (
        .clk(clk), .rst(rst), .start_i(start), .len_i(len_in),
        .echo_sclk_i(1'b0), .sdi_i(sdi1),
        .sclk_o(sclk1), .rx_data_o(data1), .rx_valid_o(valid1));

    // target boards: clock seen after a board delay, data shifted on falling edges
    always @(sclk0) tclk0 <= #17 sclk0;
    always @(sclk1) tclk1 <= #1 sclk1;

    always @(negedge tclk0 or posedge tgt_load)
        if (tgt_load) pos0 = 0; else pos0 = pos0 + 1;
    always @(negedge tclk1 or posedge tgt_load)
        if (tgt_load) pos1 = 0; else pos1 = pos1 + 1;

    always @(posedge tclk0) t_echo = $realtime;

    always_comb begin
        for (int k = 0; k < NS; k++) begin
            sdi0[k] = (pos0 < cur_len) ? pat[k][cur_len-1-pos0] : 1'b0;
            sdi1[k] = (pos1 < cur_len) ? pat[k][cur_len-1-pos1] : 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // per-cycle comparison against the reference queue
    task automatic cmp(input int i, input logic v, input logic [DW-1:0] d, input logic s);
        if (s && !prev_s[i]) begin
            rises[i]++;
            if (i == 1) rise_cyc1 = cyc;
        end
        prev_s[i] = s;
        if (v) begin
            if (head[i] == tail) begin
                check(1'b0, "R7 unexpected valid", DW'(v), '0);
            end else begin
                check(d == exp_word[head[i]], (i == 0) ? "R6/R9 echo data" : "R5/R9 direct data",
                      d, exp_word[head[i]]);
                check(rises[i] == exp_len[head[i]], "R2 sclk pulse count",
                      DW'(rises[i]), DW'(exp_len[head[i]]));
                if (i == 1)
                    check(cyc == rise_cyc1 + 1, "R7 direct valid latency", DW'(cyc - rise_cyc1), DW'(1));
                else
                    check($realtime > t_echo, "R7 valid after last echo latch", DW'(0), DW'(1));
                head[i]++;
                rises[i] = 0;
            end
        end else begin
            check(d == last_d[i], "R8 data held between strobes", d, last_d[i]);
        end
        last_d[i] = d;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && running) begin
            cmp(0, valid0, data0, sclk0);
            cmp(1, valid1, data1, sclk1);
        end
    end

    task automatic push_expected(input int len);
        logic [DW-1:0] w;
        for (int k = 0; k < NS; k++)
            for (int b = 0; b < MB; b++)
                w[k*MB + b] = (b < len) ? pat[k][b] : 1'b0;
        exp_word[tail] = w;
        exp_len[tail]  = len;
        tail++;
    endtask

    task automatic launch(input int len, input logic [MB-1:0] p0, input logic [MB-1:0] p1);
        @(negedge clk);
        pat[0] = p0; pat[1] = p1;
        cur_len = len;
        len_in  = LW'(len);
        tgt_load = 1'b1; #1 tgt_load = 1'b0;
        push_expected(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_xfer();
        while (head[0] != tail || head[1] != tail) @(posedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        last_d[0] = '0; last_d[1] = '0;
        repeat (5) @(negedge clk);
        // R1: reset state while reset is held
        check(!sclk0 && !sclk1, "R1 sclk low in reset", DW'({sclk0, sclk1}), '0);
        check(!valid0 && !valid1, "R1 valid low in reset", DW'({valid0, valid1}), '0);
        check(data0 == '0 && data1 == '0, "R1 data zero in reset", data0 | data1, '0);
        rst = 1'b0;
        @(negedge clk);
        check(!sclk0 && !valid0 && !sclk1 && !valid1, "R1 outputs after reset", DW'({sclk0, valid0, sclk1, valid1}), '0);
        running = 1'b1;

        // R5 R6 R9: assorted lengths and patterns
        launch(8, 32'h0000_00A5, 32'h0000_003C);              finish_xfer();
        launch(1, 32'h0000_0001, 32'h0000_0000);              finish_xfer();
        launch(32, 32'hDEAD_BEEF, 32'h1234_5678);             finish_xfer();
        launch(13, 32'hFFFF_FABC, 32'h0000_0F0F);             finish_xfer();
        launch(5, 32'hFFFF_FFFF, 32'h0000_0000);              finish_xfer();
        launch(32, 32'h8000_0001, 32'h7FFF_FFFE);             finish_xfer();

        // R3: a start in mid-transfer with another length is ignored
        launch(12, 32'h0000_0C35, 32'h0000_0A5A);
        repeat (6) @(negedge clk);
        len_in = LW'(3);
        start = 1'b1; @(negedge clk); start = 1'b0;
        finish_xfer();
        check(rises[0] == 0 && rises[1] == 0, "R3 no extra pulses after ignored start",
              DW'(rises[0] + rises[1]), '0);

        // R4: lengths 0 and 40 start nothing
        len_in = LW'(0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        check(rises[0] == 0 && rises[1] == 0, "R4 no sclk for length 0", DW'(rises[0] + rises[1]), '0);
        len_in = LW'(40);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        check(rises[0] == 0 && rises[1] == 0, "R4 no sclk for length 40", DW'(rises[0] + rises[1]), '0);
        check(head[0] == tail && head[1] == tail, "R4 no strobe pending", DW'(head[0] + head[1]), DW'(2 * tail));

        // back-to-back transfers after the ignored starts
        launch(7, 32'h0000_0055, 32'h0000_002A);              finish_xfer();
        launch(31, 32'h4321_8765, 32'h7654_3210);             finish_xfer();

        running = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule